// File: doc/BRIEF.md
# Refresh-synchronised slow clock generator

This block derives a slow clock from the scan chain refresh pulse rather than from the system clock. Its edges therefore always coincide with a refresh of the selected design. When the enable pin rises, the block takes a divide value N from the shared data input byte. While the enable stays high, it toggles the slow clock after every N+1 refresh pulses. The slow clock frequency is therefore the refresh rate divided by 2·(N+1).

The slow clock appears on its own output pin. It also replaces bit 0 of the input byte on the way to the selected design, so that design sees a clock on its lowest input. While the enable is low, bit 0 passes through untouched and the slow clock rests low.

All pins are plain control and data pins sampled on the system clock. No stream handshake exists at this edge, so the block never applies back-pressure. The refresh input is a one-cycle pulse produced elsewhere. The input byte is taken as-is on the cycle it is captured.

Top module: `slow_clk_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `slow_clk` is 0.
- R2: On the first rising system clock edge at which `div_en` is sampled high after being low, the low DIV_W bits of `in_byte` are captured as the divide value N.
- R3: While `div_en` stays high, changes on `in_byte` do not alter N or the toggle period.
- R4: While running, `slow_clk` toggles on exactly every (N+1)-th refresh pulse counted since arming. N=0 toggles on every refresh, and N=255 toggles every 256 refreshes.
- R5: While running, `slow_clk` changes only at clock edges where `refresh` is high, and so changes at most once per refresh.
- R6: While `div_en` is low, `slow_clk` is 0 one cycle later, and `bit0_out` equals `in_byte[0]`. Refresh pulses have no effect.
- R7: While `div_en` is high, `bit0_out` equals `slow_clk`.
- R8: Each new assertion of `div_en` restarts the refresh count at zero with `slow_clk` low, whatever state the previous run left.
- R9: A refresh pulse that coincides with the arming edge is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh | input | 1 | One-cycle pulse per scan chain refresh |
| div_en | input | 1 | Enables the slow clock; the rising edge captures N |
| in_byte | input | DATA_W | Design input byte, also the divide value source |
| slow_clk | output | 1 | Refresh-synchronised slow clock |
| bit0_out | output | 1 | Bit 0 as delivered to the design: slow clock or pass-through |

## Verification
The bound checker watches the following on every cycle:
- the divide value taken at arming and frozen afterwards;
- the refresh count never passing N;
- the slow clock holding still between refreshes and below the terminal count;
- the cleared state after arming and while disabled.

Only the bench's scenarios can show the full toggle period for each N, the ignored refresh on the arming cycle, and the restart after a mid-run re-arm. They also show the bit 0 pass-through for both input values. The bench compares each of these against an arithmetic model across a sweep of divide values.

// File: rtl/scg_pkg.sv
package scg_pkg;

  // Arming state of the divider: idle until enable is seen, then running.
  typedef enum logic {
    SCG_IDLE = 1'b0,
    SCG_RUN  = 1'b1
  } scg_mode_e;

endpackage

// File: rtl/scg_arm.sv
module scg_arm
  import scg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_en,
  input  logic [DATA_W-1:0] in_byte,
  output logic              arm,
  output logic              run,
  output logic [DIV_W-1:0]  div_q
);

  scg_mode_e mode_q;

  // arm: first enabled cycle; run: every enabled cycle after that
  assign arm = div_en && (mode_q == SCG_IDLE);
  assign run = div_en && (mode_q == SCG_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= SCG_IDLE;
    end else begin
      mode_q <= div_en ? SCG_RUN : SCG_IDLE;
    end
  end

  // Divide value is loaded only on the arming cycle, held otherwise
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (arm) begin
      div_q <= in_byte[DIV_W-1:0];
    end
  end

endmodule

// File: rtl/scg_ref_counter.sv
module scg_ref_counter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             refresh,
  input  logic [DIV_W-1:0] limit,
  output logic [DIV_W-1:0] cnt,
  output logic             tick
);

  logic at_limit;

  assign at_limit = (cnt == limit);
  assign tick     = run && refresh && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (refresh) begin
      cnt <= at_limit ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/scg_toggle.sv
module scg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic slow_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
    end else if (!run) begin
      slow_q <= 1'b0;
    end else if (tick) begin
      slow_q <= ~slow_q;
    end
  end

endmodule

// File: rtl/slow_clk_gen.sv
module slow_clk_gen #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh,
  input  logic              div_en,
  input  logic [DATA_W-1:0] in_byte,
  output logic              slow_clk,
  output logic              bit0_out
);

  logic             arm_w;
  logic             run_w;
  logic [DIV_W-1:0] div_q_w;
  logic [DIV_W-1:0] cnt_w;
  logic             tick_w;
  logic             slow_w;

  scg_arm #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_en  (div_en),
    .in_byte (in_byte),
    .arm     (arm_w),
    .run     (run_w),
    .div_q   (div_q_w)
  );

  scg_ref_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .refresh (refresh),
    .limit   (div_q_w),
    .cnt     (cnt_w),
    .tick    (tick_w)
  );

  scg_toggle u_tog (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_w),
    .tick   (tick_w),
    .slow_q (slow_w)
  );

  assign slow_clk = slow_w;
  // Enabled: the slow clock stands in for input bit 0
  assign bit0_out = div_en ? slow_w : in_byte[0];

endmodule

// File: rtl/slow_clk_gen_chk.sv
module slow_clk_gen_chk #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              refresh,
  input logic [DATA_W-1:0] in_byte,
  input logic              slow_clk,
  input logic              arm,
  input logic              run,
  input logic [DIV_W-1:0]  div_q,
  input logic [DIV_W-1:0]  cnt,
  input logic              div_en
);

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> div_q == $past(in_byte[DIV_W-1:0]));

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> div_q == $past(div_q));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= div_q);

  p_no_early_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && refresh && cnt != div_q) |=> $stable(slow_clk));

  p_quiet_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !refresh) |=> $stable(slow_clk));

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !div_en |=> !slow_clk);

  p_arm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!slow_clk && cnt == '0));

endmodule

bind slow_clk_gen slow_clk_gen_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .refresh  (refresh),
  .in_byte  (in_byte),
  .slow_clk (slow_clk),
  .arm      (arm_w),
  .run      (run_w),
  .div_q    (div_q_w),
  .cnt      (cnt_w),
  .div_en   (div_en)
);

// File: tb/slow_clk_gen_test.sv
module slow_clk_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refresh = 1'b0;
  logic       div_en = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       slow_clk;
  logic       bit0_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int   m_cnt = 0;
  int   m_n = 0;
  logic m_slow = 1'b0;

  slow_clk_gen #(.DATA_W(8)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .refresh  (refresh),
    .div_en   (div_en),
    .in_byte  (in_byte),
    .slow_clk (slow_clk),
    .bit0_out (bit0_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Arm with divide value n; r places a refresh on the arming cycle (R9)
  task automatic arm(input int n, input logic r);
    @(negedge clk);
    in_byte = n[7:0];
    div_en  = 1'b1;
    refresh = r;
    @(negedge clk);
    refresh = 1'b0;
    in_byte = ~n[7:0];   // R3: later changes must be ignored
    m_cnt = 0; m_slow = 1'b0; m_n = n;
    chk("R8 slow low after arm", int'(slow_clk), 0);
    chk("R7 bit0 follows slow after arm", int'(bit0_out), 0);
  endtask

  task automatic pulse(input int gap);
    @(negedge clk);
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
    m_cnt++;
    if (m_cnt == m_n + 1) begin
      m_cnt = 0;
      m_slow = ~m_slow;
    end
    chk("R4 slow after refresh", int'(slow_clk), int'(m_slow));
    chk("R7 bit0 equals slow", int'(bit0_out), int'(m_slow));
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk("R5 stable between refreshes", int'(slow_clk), int'(m_slow));
    end
  endtask

  task automatic disable_chk();
    @(negedge clk);
    div_en = 1'b0;
    in_byte = 8'h01;
    @(negedge clk);
    chk("R6 slow low when disabled", int'(slow_clk), 0);
    chk("R6 bit0 passes 1", int'(bit0_out), 1);
    in_byte = 8'hFE;
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
    chk("R6 bit0 passes 0", int'(bit0_out), 0);
    chk("R6 refresh ignored when disabled", int'(slow_clk), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 slow low in reset", int'(slow_clk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 slow low after reset", int'(slow_clk), 0);

    disable_chk();

    // R2/R4 sweep over small divide values plus the largest one
    for (int n = 0; n <= 10; n++) begin
      arm(n, 1'b0);
      for (int k = 0; k < 4 * (n + 1) + 1; k++) pulse(k % 3);
      disable_chk();
    end
    arm(255, 1'b0);
    for (int k = 0; k < 513; k++) pulse(0);
    disable_chk();

    // R9: refresh on the arming cycle is not counted (N=0 and N=2)
    arm(0, 1'b1);
    chk("R9 no toggle from arming refresh", int'(slow_clk), 0);
    pulse(1);
    chk("R9 first toggle on first counted refresh", int'(slow_clk), 1);
    disable_chk();
    arm(2, 1'b1);
    pulse(0); pulse(0);
    chk("R9 not yet toggled after two", int'(slow_clk), 0);
    pulse(0);
    chk("R9 toggled after three", int'(slow_clk), 1);

    // R8: re-arm mid-run with slow high and a partial count
    disable_chk();
    arm(2, 1'b0);
    for (int k = 0; k < 4; k++) pulse(1);
    chk("R8 mid-run slow high", int'(slow_clk), 1);
    @(negedge clk);
    div_en = 1'b0;
    arm(3, 1'b0);
    for (int k = 0; k < 9; k++) pulse(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule